// File: doc/BRIEF.md
# Register Command Queue Executor

This block runs a list of 64-bit commands held in a command memory and applies them, one after another, to a register space. The register space is reached through a simple request/acknowledge master port. Software writes a program into the command memory, presents its byte address on `base_addr_i` and pulses `start_i`. The engine then fetches one command at a time over a valid/ready port and executes it. It stops on a jump command, or on an error.

The command set covers five kinds of work:
- writing a register, either in full or with a bit mask;
- stalling until a register holds a given value, either in full or under a mask;
- waiting on single-bit event flags and updating them, which hardware can also set through `evt_set_i`;
- an end-of-command marker that can pulse an interrupt;
- a jump that ends the program.

A mask command arms a one-shot mask that only the command right after it can use. There is a single execution thread, so a stalled poll or event wait holds back everything behind it.

Top module: `cmd_seq_engine`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `err_o`, `irq_o`, `ifetch_valid_o`, `bus_req_o` and every event flag read 0.
- R2: On `start_i` the first fetch is issued at `base_addr_i`, and each further command is fetched 8 bytes higher. A command is laid out as opcode [63:56], subsystem [55:48], offset or event number [47:32] and value [31:0].
- R3: Opcode 0x04 writes the full 32-bit value to register address {subsystem, offset[15:1], 1'b0}. Offset bit 0 never reaches the address.
- R4: Opcode 0x02 stores the bitwise inverse of its value field as the mask M. A following 0x04 that has offset bit 0 set then leaves every register bit where M is 0 unchanged and writes the value's bits where M is 1.
- R5: An armed mask is consumed by the very next command, whatever that command is. A later write with offset bit 0 set writes all 32 bits.
- R6: Opcode 0x08 re-reads the addressed register until it equals the value field in all 32 bits. No later command runs before that.
- R7: A 0x08 command that has offset bit 0 set and directly follows a 0x02 compares only the bits where M is 1.
- R8: In opcode 0x20, value bit 15 enables waiting, and execution stalls until the numbered flag equals the OR of value bits [11:0].
- R9: In opcode 0x20, value bit 31 enables an update that writes the OR of value bits [27:16] into the flag. With only bit 31 set, the command clears the flag without waiting. A bit set on `evt_set_i` sets its flag on the next clock and overrides an engine update in the same cycle.
- R10: Opcode 0x40 with value bit 0 set gives a one-cycle `irq_o` pulse. With value bit 0 clear it gives none.
- R11: Opcode 0x10 ends the program: `busy_o` falls and `done_o` rises. With the engine idle, no fetch and no register access is requested.
- R12: An opcode outside {0x02, 0x04, 0x08, 0x10, 0x20, 0x40}, or a 0x20 whose event number is not below NEVT (default 16), stops execution with `err_o` high and `done_o` low. Both stay until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a program (honoured while idle) |
| base_addr_i | input | AW | Byte address of the first command |
| ifetch_valid_o | output | 1 | Command fetch request |
| ifetch_addr_o | output | AW | Byte address being fetched |
| ifetch_ready_i | input | 1 | Fetch accepted; data valid in the same cycle |
| ifetch_data_i | input | 64 | Fetched command |
| bus_req_o | output | 1 | Register access request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 24 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | 32 | Read data |
| evt_set_i | input | NEVT | Hardware event set strobes |
| evt_flags_o | output | NEVT | Event flag scoreboard |
| irq_o | output | 1 | End-of-command interrupt pulse |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | Last program ended with a jump |
| err_o | output | 1 | Last program stopped on an error |

## Verification
The assertions assume that the register bus answers only a pending request, with at most one acknowledge per request cycle and read data valid alongside it. They also assume that fetch data is valid whenever ready is high, and that `start_i` is pulsed only while the engine is idle. The bench's register model acknowledges one cycle after it sees a request and then drops the acknowledge for a cycle. Its command memory is always ready. It raises `start_i` only after the previous run has ended, and it drives event strobes as single-cycle pulses between clock edges.

// File: rtl/cqx_pkg.sv
package cqx_pkg;

    localparam int INSN_W  = 64;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = 16;
    localparam int SUB_W   = 8;
    localparam int RADDR_W = SUB_W + OFF_W;

    // opcode values
    localparam logic [7:0] OPC_MASK  = 8'h02;
    localparam logic [7:0] OPC_WRITE = 8'h04;
    localparam logic [7:0] OPC_POLL  = 8'h08;
    localparam logic [7:0] OPC_JUMP  = 8'h10;
    localparam logic [7:0] OPC_WFE   = 8'h20;
    localparam logic [7:0] OPC_EOC   = 8'h40;

    typedef struct packed {
        logic [7:0]        op;
        logic [SUB_W-1:0]  sub;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] val;
    } insn_t;

    typedef enum logic [1:0] {
        RK_WRITE  = 2'd0,
        RK_MWRITE = 2'd1,
        RK_POLL   = 2'd2
    } rkind_e;

    typedef struct packed {
        rkind_e             kind;
        logic [RADDR_W-1:0] addr;
        logic [DATA_W-1:0]  val;
        logic [DATA_W-1:0]  mask;
    } rcmd_t;

    function automatic logic [RADDR_W-1:0] reg_addr(input insn_t i);
        return {i.sub, i.off[OFF_W-1:1], 1'b0};
    endfunction

    function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [DATA_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // event command option fields
    function automatic logic wfe_wait_en(input logic [DATA_W-1:0] v);
        return v[15];
    endfunction
    function automatic logic wfe_wait_lvl(input logic [DATA_W-1:0] v);
        return |v[11:0];
    endfunction
    function automatic logic wfe_upd_en(input logic [DATA_W-1:0] v);
        return v[31];
    endfunction
    function automatic logic wfe_upd_lvl(input logic [DATA_W-1:0] v);
        return |v[27:16];
    endfunction

endpackage

// File: rtl/cqx_fetch.sv
module cqx_fetch
    import cqx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [AW-1:0]     base_i,
    input  logic              go_i,
    output logic              ifetch_valid_o,
    output logic [AW-1:0]     ifetch_addr_o,
    input  logic              ifetch_ready_i,
    input  logic [INSN_W-1:0] ifetch_data_i,
    output insn_t             insn_o,
    output logic              got_o
);

    localparam logic [AW-1:0] STEP = AW'(INSN_W / 8);

    logic [AW-1:0] pc_q;
    logic          req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            req_q  <= 1'b0;
            got_o  <= 1'b0;
            insn_o <= '0;
        end else begin
            got_o <= 1'b0;
            if (load_i) begin
                pc_q  <= base_i;
                req_q <= 1'b0;
            end else if (req_q && ifetch_ready_i) begin
                req_q  <= 1'b0;
                got_o  <= 1'b1;
                insn_o <= insn_t'(ifetch_data_i);
                pc_q   <= pc_q + STEP;
            end else if (go_i) begin
                req_q <= 1'b1;
            end
        end
    end

    assign ifetch_valid_o = req_q;
    assign ifetch_addr_o  = pc_q;

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ifetch_valid_o && !ifetch_ready_i) |=> (ifetch_valid_o && $stable(ifetch_addr_o))) // R2
        else $error("fetch request dropped");

endmodule

// File: rtl/cqx_events.sv
module cqx_events #(
    parameter int NEVT = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEVT-1:0] evt_set_i,
    input  logic            upd_en_i,
    input  logic [15:0]     upd_idx_i,
    input  logic            upd_val_i,
    output logic [NEVT-1:0] flags_o
);

    logic [NEVT-1:0] nxt;

    always_comb begin
        nxt = flags_o;
        for (int k = 0; k < NEVT; k++) begin
            if (upd_en_i && (upd_idx_i == 16'(k))) nxt[k] = upd_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= nxt | evt_set_i;
    end

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt_set_i != '0) |=> ((flags_o & $past(evt_set_i)) == $past(evt_set_i))) // R9
        else $error("hardware event set lost");

endmodule

// File: rtl/cqx_regport.sv
module cqx_regport
    import cqx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  rcmd_t              cmd_i,
    output logic               done_o,
    output logic               bus_req_o,
    output logic               bus_we_o,
    output logic [RADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0]  bus_wdata_o,
    input  logic               bus_ack_i,
    input  logic [DATA_W-1:0]  bus_rdata_i
);

    typedef enum logic [1:0] {RP_IDLE, RP_READ, RP_WRITE} rp_e;

    rp_e               st;
    rcmd_t             cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hit;

    assign hit = ((bus_rdata_i ^ cmd_q.val) & cmd_q.mask) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RP_IDLE;
            cmd_q   <= '0;
            wdata_q <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                RP_IDLE: if (start_i) begin
                    cmd_q   <= cmd_i;
                    wdata_q <= cmd_i.val;
                    st      <= (cmd_i.kind == RK_WRITE) ? RP_WRITE : RP_READ;
                end
                RP_READ: if (bus_ack_i) begin
                    if (cmd_q.kind == RK_POLL) begin
                        if (hit) begin
                            st     <= RP_IDLE;
                            done_o <= 1'b1;
                        end
                    end else begin
                        wdata_q <= merge_bits(bus_rdata_i, cmd_q.val, cmd_q.mask);
                        st      <= RP_WRITE;
                    end
                end
                RP_WRITE: if (bus_ack_i) begin
                    st     <= RP_IDLE;
                    done_o <= 1'b1;
                end
                default: st <= RP_IDLE;
            endcase
        end
    end

    assign bus_req_o   = (st != RP_IDLE);
    assign bus_we_o    = (st == RP_WRITE);
    assign bus_addr_o  = cmd_q.addr;
    assign bus_wdata_o = wdata_q;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o))) // R3
        else $error("register request changed before acknowledge");

endmodule

// File: rtl/cmd_seq_engine.sv
module cmd_seq_engine
    import cqx_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NEVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [AW-1:0]      base_addr_i,
    output logic               ifetch_valid_o,
    output logic [AW-1:0]      ifetch_addr_o,
    input  logic               ifetch_ready_i,
    input  logic [INSN_W-1:0]  ifetch_data_i,
    output logic               bus_req_o,
    output logic               bus_we_o,
    output logic [RADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0]  bus_wdata_o,
    input  logic               bus_ack_i,
    input  logic [DATA_W-1:0]  bus_rdata_i,
    input  logic [NEVT-1:0]    evt_set_i,
    output logic [NEVT-1:0]    evt_flags_o,
    output logic               irq_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);

    typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_EXEC, S_REG, S_EVT} st_e;

    st_e               st;
    insn_t             ins;
    logic              got;
    logic [DATA_W-1:0] mask_q;
    logic              armed;
    logic              rp_start, rp_done;
    rcmd_t             rp_cmd;
    logic              use_mask;
    logic              evt_ok, evt_now, evt_match;
    logic [NEVT-1:0]   fsh;
    logic              upd_en;
    logic              fetch_load, fetch_go;

    assign fetch_load = (st == S_IDLE) && start_i;
    assign fetch_go   = (st == S_ISSUE);

    cqx_fetch #(.AW(AW)) i_fetch (
        .clk            (clk),
        .rst            (rst),
        .load_i         (fetch_load),
        .base_i         (base_addr_i),
        .go_i           (fetch_go),
        .ifetch_valid_o (ifetch_valid_o),
        .ifetch_addr_o  (ifetch_addr_o),
        .ifetch_ready_i (ifetch_ready_i),
        .ifetch_data_i  (ifetch_data_i),
        .insn_o         (ins),
        .got_o          (got)
    );

    // register command build
    assign use_mask    = ins.off[0] && armed;
    assign rp_cmd.kind = (ins.op == OPC_POLL) ? RK_POLL : (use_mask ? RK_MWRITE : RK_WRITE);
    assign rp_cmd.addr = reg_addr(ins);
    assign rp_cmd.val  = ins.val;
    assign rp_cmd.mask = use_mask ? mask_q : '1;
    assign rp_start    = (st == S_EXEC) && ((ins.op == OPC_WRITE) || (ins.op == OPC_POLL));

    cqx_regport i_regport (
        .clk         (clk),
        .rst         (rst),
        .start_i     (rp_start),
        .cmd_i       (rp_cmd),
        .done_o      (rp_done),
        .bus_req_o   (bus_req_o),
        .bus_we_o    (bus_we_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_ack_i   (bus_ack_i),
        .bus_rdata_i (bus_rdata_i)
    );

    // event scoreboard access
    assign evt_ok    = ins.off < 16'(NEVT);
    assign fsh       = evt_flags_o >> ins.off;
    assign evt_now   = fsh[0];
    assign evt_match = (evt_now == wfe_wait_lvl(ins.val));
    assign upd_en    = wfe_upd_en(ins.val) &&
                       (((st == S_EXEC) && (ins.op == OPC_WFE) && evt_ok && !wfe_wait_en(ins.val)) ||
                        ((st == S_EVT) && evt_match));

    cqx_events #(.NEVT(NEVT)) i_events (
        .clk       (clk),
        .rst       (rst),
        .evt_set_i (evt_set_i),
        .upd_en_i  (upd_en),
        .upd_idx_i (ins.off),
        .upd_val_i (wfe_upd_lvl(ins.val)),
        .flags_o   (evt_flags_o)
    );

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            irq_o  <= 1'b0;
            armed  <= 1'b0;
            mask_q <= '0;
        end else begin
            irq_o <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    busy_o <= 1'b1;
                    done_o <= 1'b0;
                    err_o  <= 1'b0;
                    armed  <= 1'b0;
                    st     <= S_ISSUE;
                end
                S_ISSUE: st <= S_WAIT;
                S_WAIT:  if (got) st <= S_EXEC;
                S_EXEC: begin
                    armed <= 1'b0;
                    case (ins.op)
                        OPC_MASK: begin
                            mask_q <= ~ins.val;
                            armed  <= 1'b1;
                            st     <= S_ISSUE;
                        end
                        OPC_WRITE, OPC_POLL: st <= S_REG;
                        OPC_WFE: begin
                            if (!evt_ok) begin
                                err_o  <= 1'b1;
                                busy_o <= 1'b0;
                                st     <= S_IDLE;
                            end else if (wfe_wait_en(ins.val)) begin
                                st <= S_EVT;
                            end else begin
                                st <= S_ISSUE;
                            end
                        end
                        OPC_EOC: begin
                            irq_o <= ins.val[0];
                            st    <= S_ISSUE;
                        end
                        OPC_JUMP: begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                            st     <= S_IDLE;
                        end
                        default: begin
                            err_o  <= 1'b1;
                            busy_o <= 1'b0;
                            st     <= S_IDLE;
                        end
                    endcase
                end
                S_REG: if (rp_done) st <= S_ISSUE;
                S_EVT: if (evt_match) st <= S_ISSUE;
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o) // R10
        else $error("interrupt longer than one cycle");

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)) // R12
        else $error("done and error together");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!bus_req_o && !ifetch_valid_o)) // R11
        else $error("activity while idle");

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> !ifetch_valid_o) // R6
        else $error("fetch overlaps register access");

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !done_o && !err_o)) // R12
        else $error("start did not clear status");

endmodule

// File: tb/test_cmd_seq_engine.sv
module test_cmd_seq_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic        ifv;
    logic [31:0] ifa;
    logic [63:0] ifd;
    logic        breq, bwe;
    logic [23:0] baddr;
    logic [31:0] bwdata;
    logic        back = 1'b0;
    logic [31:0] brdata = '0;
    logic [15:0] evt_set = '0;
    logic [15:0] flags;
    logic        irq, busy, done, err;

    always #5 clk = ~clk;

    cmd_seq_engine i_cmd_seq_engine (
        .clk(clk), .rst(rst), .start_i(start), .base_addr_i(base),
        .ifetch_valid_o(ifv), .ifetch_addr_o(ifa), .ifetch_ready_i(1'b1), .ifetch_data_i(ifd),
        .bus_req_o(breq), .bus_we_o(bwe), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
        .bus_ack_i(back), .bus_rdata_i(brdata),
        .evt_set_i(evt_set), .evt_flags_o(flags),
        .irq_o(irq), .busy_o(busy), .done_o(done), .err_o(err)
    );

    logic [63:0] imem [32];
    logic [31:0] regs [16];
    logic [23:0] last_wa = '0;
    int          irq_cnt = 0;
    logic [31:0] first_fa = '0;
    bit          seen = 1'b0;
    int          nchk = 0, nfail = 0;

    assign ifd = imem[ifa[7:3]];

    // register space model, acknowledge one cycle after a request
    always @(negedge clk) begin
        if (back) back = 1'b0;
        else if (breq) begin
            back = 1'b1;
            if (bwe) begin
                regs[baddr[4:1]] = bwdata;
                last_wa = baddr;
            end else brdata = regs[baddr[4:1]];
        end
        if (irq) irq_cnt++;
        if (ifv && !seen) begin first_fa = ifa; seen = 1'b1; end
    end

    function automatic logic [63:0] mk(input logic [7:0] op, input logic [7:0] sb,
                                       input logic [15:0] of, input logic [31:0] v);
        return {op, sb, of, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr_mem();
        for (int k = 0; k < 32; k++) imem[k] = '0;
    endtask

    task automatic run(input logic [31:0] b, input int lim, output bit to);
        @(negedge clk);
        base = b; start = 1'b1; seen = 1'b0;
        @(negedge clk);
        start = 1'b0;
        to = 1'b1;
        for (int c = 0; c < lim; c++) begin
            if (done || err) begin to = 1'b0; break; end
            @(negedge clk);
        end
    endtask

    // masked, sub, off, init, val, mask, expected
    localparam int VW = 1 + 8 + 16 + 32 * 4;
    localparam logic [VW-1:0] VEC [6] = '{
        {1'b0, 8'h12, 16'h0004, 32'hFFFF0000, 32'h12345678, 32'hFFFFFFFF, 32'h12345678},
        {1'b0, 8'h03, 16'h0007, 32'hAAAAAAAA, 32'h00000001, 32'hFFFFFFFF, 32'h00000001},
        {1'b1, 8'h20, 16'h000B, 32'hFFFFFFFF, 32'h00000000, 32'h0000FF00, 32'hFFFF00FF},
        {1'b1, 8'h44, 16'h0011, 32'h12345678, 32'hABCDEF01, 32'hF0F0F0F0, 32'hA2C4E608},
        {1'b1, 8'h00, 16'h001F, 32'h00000000, 32'hFFFFFFFF, 32'h80000001, 32'h80000001},
        {1'b0, 8'hFE, 16'hFFFE, 32'h00000005, 32'hDEADBEEF, 32'hFFFFFFFF, 32'hDEADBEEF}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog act=%h exp=%h", busy, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit to;
        int irq0;
        for (int k = 0; k < 16; k++) regs[k] = '0;
        clr_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, err, irq, ifv, breq} == 6'b0, "R1 status", {26'd0, busy, done, err, irq, ifv, breq}, 32'd0);
        chk(flags == '0, "R1 flags", {16'd0, flags}, 32'd0);
        rst = 1'b0;

        // vector table: R3 / R4 writes with EOC interrupt and jump
        for (int v = 0; v < 6; v++) begin
            logic        vm;
            logic [7:0]  vs;
            logic [15:0] vo;
            logic [31:0] vi, vv, vk, ve;
            int          p;
            {vm, vs, vo, vi, vv, vk, ve} = VEC[v];
            clr_mem();
            p = 0;
            if (vm) begin imem[p] = mk(8'h02, 8'h00, 16'h0000, ~vk); p++; end
            imem[p] = mk(8'h04, vs, vo, vv); p++;
            imem[p] = mk(8'h40, 8'h00, 16'h0000, 32'h1); p++;
            imem[p] = mk(8'h10, 8'h00, 16'h0000, 32'h1);
            regs[vo[4:1]] = vi;
            irq0 = irq_cnt;
            run(32'h0, 200, to);
            chk(!to && done && !err, vm ? "R4 done" : "R3 done", {30'd0, done, err}, 32'h2);
            chk(regs[vo[4:1]] == ve, vm ? "R4 data" : "R3 data", regs[vo[4:1]], ve);
            chk(last_wa == {vs, vo[15:1], 1'b0}, "R3 addr", {8'd0, last_wa}, {8'd0, vs, vo[15:1], 1'b0});
            chk(irq_cnt == irq0 + 1, "R10 irq", irq_cnt, irq0 + 1);
            chk(!busy, "R11 idle", {31'd0, busy}, 32'd0);
        end

        // R5 mask is one-shot; R2 base address; R10 no irq with bit0 clear
        clr_mem();
        imem[8]  = mk(8'h02, 8'h00, 16'h0000, ~32'h000000FF);
        imem[9]  = mk(8'h04, 8'h00, 16'h0003, 32'h00000011);
        imem[10] = mk(8'h04, 8'h00, 16'h0003, 32'hCAFE0022);
        imem[11] = mk(8'h40, 8'h00, 16'h0000, 32'h0);
        imem[12] = mk(8'h10, 8'h00, 16'h0000, 32'h1);
        regs[1] = 32'hFFFFFF00;
        irq0 = irq_cnt;
        run(32'h40, 200, to);
        chk(first_fa == 32'h40, "R2 first fetch", first_fa, 32'h40);
        chk(!to && done, "R2 step", {31'd0, done}, 32'd1);
        chk(regs[1] == 32'hCAFE0022, "R5 one-shot", regs[1], 32'hCAFE0022);
        chk(irq_cnt == irq0, "R10 no irq", irq_cnt, irq0);

        // R6 full poll stalls until equal
        clr_mem();
        imem[0] = mk(8'h08, 8'h00, 16'h0008, 32'h00000055);
        imem[1] = mk(8'h40, 8'h00, 16'h0000, 32'h1);
        imem[2] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        regs[4] = 32'h00000155;
        irq0 = irq_cnt;
        run(32'h0, 40, to);
        chk(to && busy && !done, "R6 stall", {30'd0, busy, done}, 32'h2);
        chk(irq_cnt == irq0, "R6 nothing after poll", irq_cnt, irq0);
        regs[4] = 32'h00000055;
        for (int c = 0; c < 50 && !done; c++) @(negedge clk);
        chk(done && irq_cnt == irq0 + 1, "R6 release", irq_cnt, irq0 + 1);

        // R7 masked poll ignores unmasked bits
        clr_mem();
        imem[0] = mk(8'h02, 8'h00, 16'h0000, ~32'hFFFF0000);
        imem[1] = mk(8'h08, 8'h00, 16'h000D, 32'h1234ABCD);
        imem[2] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        regs[6] = 32'h12340000;
        run(32'h0, 60, to);
        chk(!to && done, "R7 masked poll", {31'd0, done}, 32'd1);

        // R8 wait on event 3, then R9 clear through update
        clr_mem();
        imem[0] = mk(8'h20, 8'h00, 16'h0003, 32'h80008001);
        imem[1] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        run(32'h0, 20, to);
        chk(to && busy && !done, "R8 wait stall", {30'd0, busy, done}, 32'h2);
        evt_set[3] = 1'b1;
        @(negedge clk);
        evt_set[3] = 1'b0;
        for (int c = 0; c < 20 && !done; c++) @(negedge clk);
        chk(done, "R8 wait release", {31'd0, done}, 32'd1);
        chk(flags[3] == 1'b0, "R9 update clears", {31'd0, flags[3]}, 32'd0);

        // R9 set via update value, then clear-event form
        clr_mem();
        imem[0] = mk(8'h20, 8'h00, 16'h0005, 32'h80010000);
        imem[1] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        run(32'h0, 40, to);
        chk(!to && flags[5], "R9 set", {31'd0, flags[5]}, 32'd1);
        imem[0] = mk(8'h20, 8'h00, 16'h0005, 32'h80000000);
        run(32'h0, 40, to);
        chk(!to && done && !flags[5], "R9 clear", {31'd0, flags[5]}, 32'd0);

        // R12 undefined opcode and event out of range
        clr_mem();
        imem[0] = mk(8'h55, 8'h00, 16'h0000, 32'h0);
        imem[1] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        run(32'h0, 40, to);
        repeat (3) @(negedge clk);
        chk(err && !done && !busy, "R12 bad opcode", {29'd0, err, done, busy}, 32'h4);
        imem[0] = mk(8'h20, 8'h00, 16'h0010, 32'h80000000);
        run(32'h0, 40, to);
        chk(err && !done, "R12 bad event", {30'd0, err, done}, 32'h2);
        imem[0] = mk(8'h10, 8'h00, 16'h0000, 32'h0);
        run(32'h0, 40, to);
        chk(done && !err, "R12 restart clears", {30'd0, err, done}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule